// File: doc/BRIEF.md
# Vectored Interrupt Aggregator

This block gathers a parameterised set of interrupt request lines (32 by default) and folds them into a single interrupt line toward a processor. Each request passes through a two-flop synchronizer. It is then captured into a status register in one of two ways, chosen per source at build time. A level-type source mirrors its synchronized input. An edge-type source latches on a rising edge and keeps its bit until software acknowledges it.

Software reaches the block through a simple word-addressed register port with read and write strobes. Eight word registers sit at offsets 0 to 7:

| Offset | Register |
|---|---|
| 0 | status |
| 1 | pending |
| 2 | enable |
| 3 | acknowledge |
| 4 | set-enable |
| 5 | clear-enable |
| 6 | vector |
| 7 | master control |

Pending is the AND of status and enable. The vector register names the lowest pending source. The master control register has two bits: bit 0 gates the output and bit 1 gates hardware capture.

Top module: `irq_merge_ctrl`

## Requirements
- R1: A synchronous active-high reset clears status, enable and master control, drives irq_o low, and leaves the vector register reading 0xFFFFFFFF.
- R2: Reading offset 1 returns the bitwise AND of status and enable.
- R3: Reading offset 6 returns the index of the lowest-numbered set bit of pending, or 0xFFFFFFFF when pending is zero.
- R4: irq_o is high only when master control bit 0 and bit 1 are both set and pending is nonzero. It updates on the same clock edge as the registers it depends on.
- R5: A write to offset 3 clears each status bit whose position is 1 in the write data and leaves the other status bits alone.
- R6: A write to offset 4 ORs the data into enable. A write to offset 5 clears the enable bits that are 1 in the data.
- R7: While master control bit 1 is 0, request inputs are not captured into status, and irq_o stays low.
- R8: For a source whose bit in the EDGE_MASK parameter is 0 (level-type), its status bit follows the synchronized input level while capture is enabled.
- R9: For a source whose EDGE_MASK bit is 1 (edge-type), a rising edge of the synchronized input sets its status bit. The bit stays set after the input falls, until it is acknowledged.
- R10: Writes to offsets 0, 2 and 7 store the data. Writes to offsets 1 and 6 have no effect. A read returns its value on rdata after the clock edge that samples rd_en.
- R11: An input change appears in status, and in irq_o, on the third rising clock edge after it is applied.
- R12: When an acknowledge write and a newly detected rising edge hit the same source on the same edge, the status bit ends up set.
- R13: Addresses 8 and above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after rd_en |
| irq_src | input | N_SRC | Interrupt request inputs, asynchronous |
| irq_o | output | 1 | Merged interrupt toward the processor |

## Verification
The bench builds the block with 32 sources and EDGE_MASK = 0xFFFF0000. Sources 0 to 15 are therefore level-type and sources 16 to 31 edge-type, so both capture paths and their interplay with acknowledge and status writes are within reach in one build. A 4-bit address lets the bench reach the unmapped offsets 8 to 15. The enable pattern mixes sources of both kinds, so the vector and pending results depend on which kind latched.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

    localparam int unsigned NREG = 8;

    typedef enum logic [2:0] {
        OFF_STATUS = 3'd0,
        OFF_PEND   = 3'd1,
        OFF_EN     = 3'd2,
        OFF_ACK    = 3'd3,
        OFF_SETEN  = 3'd4,
        OFF_CLREN  = 3'd5,
        OFF_VEC    = 3'd6,
        OFF_MCTL   = 3'd7
    } reg_off_e;

    localparam int unsigned MCTL_OUT_BIT = 0;
    localparam int unsigned MCTL_CAP_BIT = 1;

endpackage

// File: rtl/irq_merge_sync.sv
// Two-flop synchronizer per request line plus a rising-edge detector.
module irq_merge_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.s2;
    assign rise_o = st_q.s2 & ~st_q.prev;

    // R9: a detected edge lasts one cycle only
    p_rise_single_r9: assert property (@(posedge clk) disable iff (rst)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/irq_merge_capture.sv
// Status register with per-source edge or level capture.
module irq_merge_capture #(
    parameter int unsigned       N         = 32,
    parameter logic [N-1:0]      EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_en_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] rise_i,
    input  logic         sw_load_i,
    input  logic [N-1:0] sw_val_i,
    input  logic [N-1:0] sw_clr_i,
    output logic [N-1:0] status_d_o,
    output logic [N-1:0] status_q_o
);

    logic [N-1:0] status_d, status_q;
    logic [N-1:0] after_sw;

    // software effect first, hardware capture applied on top of it
    always_comb begin
        if (sw_load_i) begin
            after_sw = sw_val_i;
        end else begin
            after_sw = status_q & ~sw_clr_i;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            assign status_d[i] = after_sw[i] | (cap_en_i & rise_i[i]);

            // R9: latched bit survives unless software clears or reloads it
            p_edge_hold_r9: assert property (@(posedge clk) disable iff (rst)
                (status_q[i] && !sw_load_i && !sw_clr_i[i]) |=> status_q[i]);
            // R12: an edge beats a same-cycle acknowledge
            p_edge_wins_r12: assert property (@(posedge clk) disable iff (rst)
                (cap_en_i && rise_i[i] && sw_clr_i[i]) |=> status_q[i]);
        end else begin : g_level
            assign status_d[i] = cap_en_i ? lvl_i[i] : after_sw[i];

            // R8: level source mirrors the synchronized input while capturing
            p_level_track_r8: assert property (@(posedge clk) disable iff (rst)
                cap_en_i |=> (status_q[i] == $past(lvl_i[i])));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_d_o = status_d;
    assign status_q_o = status_q;

    // R7: without capture and without software, status is frozen
    p_no_capture_r7: assert property (@(posedge clk) disable iff (rst)
        (!cap_en_i && !sw_load_i && sw_clr_i == '0) |=> $stable(status_q));

endmodule

// File: rtl/irq_merge_lowest.sv
// Lowest set bit finder for the vector register.
module irq_merge_lowest #(
    parameter int unsigned N    = 32,
    parameter int unsigned IDXW = $clog2(N)
) (
    input  logic [N-1:0]    pend_i,
    output logic            any_o,
    output logic [IDXW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IDXW'(i);
            end
        end
        any_o = |pend_i;
    end

endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
    import irq_merge_pkg::*;
#(
    parameter int unsigned      N_SRC     = 32,
    parameter int unsigned      DW        = 32,
    parameter int unsigned      AW        = 4,
    parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [N_SRC-1:0] irq_src,
    output logic             irq_o
);

    localparam int unsigned IDXW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        logic [N_SRC-1:0] enable;
        logic [DW-1:0]    mctl;
        logic [DW-1:0]    rdata;
        logic             irq;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [N_SRC-1:0] lvl, rise;
    logic [N_SRC-1:0] status_d, status_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] wdat_src;
    logic [N_SRC-1:0] sw_clr;
    logic             sw_load;
    logic             vec_any;
    logic [IDXW-1:0]  vec_idx;
    logic [AW:0]      addr_ext;
    logic             in_win;
    logic             wr_hit;
    reg_off_e         off;

    assign addr_ext = {1'b0, addr};
    assign in_win   = (addr_ext < (AW+1)'(NREG));
    assign off      = reg_off_e'(addr[2:0]);
    assign wr_hit   = wr_en & in_win;
    assign wdat_src = wdata[N_SRC-1:0];
    assign sw_load  = wr_hit && (off == OFF_STATUS);
    assign sw_clr   = (wr_hit && (off == OFF_ACK)) ? wdat_src : '0;
    assign pend_q   = status_q & st_q.enable;

    irq_merge_sync #(
        .W (N_SRC)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (irq_src),
        .lvl_o  (lvl),
        .rise_o (rise)
    );

    irq_merge_capture #(
        .N         (N_SRC),
        .EDGE_MASK (EDGE_MASK)
    ) u_capture (
        .clk        (clk),
        .rst        (rst),
        .cap_en_i   (st_q.mctl[MCTL_CAP_BIT]),
        .lvl_i      (lvl),
        .rise_i     (rise),
        .sw_load_i  (sw_load),
        .sw_val_i   (wdat_src),
        .sw_clr_i   (sw_clr),
        .status_d_o (status_d),
        .status_q_o (status_q)
    );

    irq_merge_lowest #(
        .N    (N_SRC),
        .IDXW (IDXW)
    ) u_lowest (
        .pend_i (pend_q),
        .any_o  (vec_any),
        .idx_o  (vec_idx)
    );

    always_comb begin
        st_d = st_q;

        if (wr_hit) begin
            unique case (off)
                OFF_EN:    st_d.enable = wdat_src;
                OFF_SETEN: st_d.enable = st_q.enable | wdat_src;
                OFF_CLREN: st_d.enable = st_q.enable & ~wdat_src;
                OFF_MCTL:  st_d.mctl   = wdata;
                default:   st_d.enable = st_q.enable;
            endcase
        end

        if (rd_en) begin
            if (!in_win) begin
                st_d.rdata = '0;
            end else begin
                unique case (off)
                    OFF_STATUS: st_d.rdata = DW'(status_q);
                    OFF_PEND:   st_d.rdata = DW'(pend_q);
                    OFF_EN:     st_d.rdata = DW'(st_q.enable);
                    OFF_VEC:    st_d.rdata = vec_any ? DW'(vec_idx) : '1;
                    OFF_MCTL:   st_d.rdata = st_q.mctl;
                    default:    st_d.rdata = '0;
                endcase
            end
        end

        st_d.irq = st_d.mctl[MCTL_OUT_BIT] & st_d.mctl[MCTL_CAP_BIT]
                 & (|(status_d & st_d.enable));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign irq_o = st_q.irq;

    // R5: acknowledged bits are gone one edge later when capture is off
    p_ack_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_win && addr[2:0] == 3'd3 && !st_q.mctl[MCTL_CAP_BIT])
        |=> ((status_q & $past(wdata[N_SRC-1:0])) == '0));
    // R6: set-enable leaves every written bit enabled
    p_set_en_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_win && addr[2:0] == 3'd4)
        |=> ((st_q.enable & $past(wdata[N_SRC-1:0])) == $past(wdata[N_SRC-1:0])));
    // R6: clear-enable removes every written bit
    p_clr_en_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_win && addr[2:0] == 3'd5)
        |=> ((st_q.enable & $past(wdata[N_SRC-1:0])) == '0));
    // R4: output needs both control bits
    p_out_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (!st_q.mctl[MCTL_OUT_BIT] || !st_q.mctl[MCTL_CAP_BIT]) |-> !irq_o);
    // R4: raised output implies a pending source
    p_out_pending_r4: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_q != '0));
    // R3: the vector names the lowest pending source
    p_vec_lowest_r3: assert property (@(posedge clk) disable iff (rst)
        vec_any |-> (pend_q[vec_idx]
                     && ((pend_q & ((N_SRC'(1) << vec_idx) - N_SRC'(1))) == '0)));
    // R13: unmapped reads return zero
    p_oor_read_r13: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !in_win) |=> (rdata == '0));
    // R13: unmapped writes leave enable and control alone
    p_oor_write_r13: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_win) |=> ($stable(st_q.enable) && $stable(st_q.mctl)));

endmodule

// File: tb/irq_merge_ctrl_bench.sv
`timescale 1ns/1ps
module irq_merge_ctrl_bench;

    localparam int unsigned N  = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [N-1:0]  src = '0;
    logic          irq_o;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    exp_item_t cur;

    always #2.5 clk = ~clk;

    irq_merge_ctrl #(
        .N_SRC     (N),
        .DW        (DW),
        .AW        (AW),
        .EDGE_MASK (32'hFFFF_0000)
    ) u_irq_merge_ctrl (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_src (src),
        .irq_o   (irq_o)
    );

    // monitor: compares each read return against the scoreboard
    always @(posedge clk) begin
        if (rd_en) begin
            #1;
            if (sb_q.size() == 0) begin
                checks++;
                bad++;
                $display("FAIL R10 read with no expectation: rdata=%h expected none", rdata);
            end else begin
                cur = sb_q.pop_front();
                checks++;
                if (rdata !== cur.exp) begin
                    bad++;
                    $display("FAIL %s: rdata=%h expected %h", cur.tag, rdata, cur.exp);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        exp_item_t it;
        it.exp = e;
        it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq_o !== e) begin
            bad++;
            $display("FAIL %s: irq_o=%b expected %b", tag, irq_o, e);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;

        // R1: reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(4'd0, 32'h0, "R1 status after reset");
        rd(4'd1, 32'h0, "R1 pending after reset");
        rd(4'd2, 32'h0, "R1 enable after reset");
        rd(4'd7, 32'h0, "R1 control after reset");
        rd(4'd6, 32'hFFFF_FFFF, "R1 vector after reset");

        // R10: direct stores and ignored offsets
        wr(4'd2, 32'hA5A5_0F0F);
        rd(4'd2, 32'hA5A5_0F0F, "R10 enable store");
        wr(4'd7, 32'h0000_0003);
        rd(4'd7, 32'h0000_0003, "R10 control store");
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, 32'h0, "R10 pending write ignored");
        wr(4'd6, 32'h0000_0000);
        rd(4'd6, 32'hFFFF_FFFF, "R10 vector write ignored");

        // R2 R3 R4: status store drives pending, vector, output
        wr(4'd0, 32'h0030_0000);
        rd(4'd0, 32'h0030_0000, "R10 status store");
        rd(4'd1, 32'h0020_0000, "R2 pending is status and enable");
        rd(4'd6, 32'd21, "R3 vector lowest pending");
        chk_irq(1'b1, "R4 irq with pending");

        // R5: acknowledge
        wr(4'd3, 32'h0020_0000);
        rd(4'd0, 32'h0010_0000, "R5 ack clears only written bits");
        rd(4'd6, 32'hFFFF_FFFF, "R3 vector when nothing pending");
        chk_irq(1'b0, "R4 irq low with nothing pending");

        // R6: atomic enable updates
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd2, 32'h0, "R6 clear-enable all");
        wr(4'd4, 32'h0000_0003);
        wr(4'd4, 32'h0001_0000);
        rd(4'd2, 32'h0001_0003, "R6 set-enable accumulates");
        wr(4'd5, 32'h0000_0001);
        rd(4'd2, 32'h0001_0002, "R6 clear-enable one bit");

        // R8: level source follows input
        src[1] = 1'b1;
        wait_cyc(4);
        rd(4'd0, 32'h0010_0002, "R8 level source high");
        rd(4'd6, 32'd1, "R3 vector level source");
        chk_irq(1'b1, "R8 irq from level source");
        src[1] = 1'b0;
        wait_cyc(4);
        rd(4'd0, 32'h0010_0000, "R8 level source low");
        chk_irq(1'b0, "R8 irq drops with level");

        // R11: three-edge capture latency
        @(negedge clk);
        src[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_irq(1'b0, "R11 irq not yet after two edges");
        @(negedge clk);
        chk_irq(1'b1, "R11 irq after third edge");
        src[1] = 1'b0;
        wait_cyc(4);

        // R9: edge source latches
        src[16] = 1'b1;
        wait_cyc(4);
        rd(4'd0, 32'h0011_0000, "R9 edge source set");
        src[16] = 1'b0;
        wait_cyc(4);
        rd(4'd0, 32'h0011_0000, "R9 edge source held after input falls");
        rd(4'd6, 32'd16, "R3 vector edge source");
        chk_irq(1'b1, "R9 irq held by edge source");
        wr(4'd3, 32'h0001_0000);
        rd(4'd0, 32'h0010_0000, "R9 edge cleared by ack");
        chk_irq(1'b0, "R9 irq low after ack");

        // R12: ack and new edge on the same edge
        wr(4'd0, 32'h0011_0000);
        src[16] = 1'b1;
        @(negedge clk);
        wr(4'd3, 32'h0001_0000);
        rd(4'd0, 32'h0011_0000, "R12 new edge beats ack");
        src[16] = 1'b0;
        wait_cyc(4);
        wr(4'd3, 32'h0001_0000);
        rd(4'd0, 32'h0010_0000, "R12 later ack clears");

        // R7: capture disabled
        wr(4'd7, 32'h0000_0001);
        src[1] = 1'b1;
        wait_cyc(4);
        rd(4'd0, 32'h0010_0000, "R7 input ignored without capture");
        wr(4'd0, 32'h0001_0000);
        chk_irq(1'b0, "R7 irq forced low without capture");
        rd(4'd1, 32'h0001_0000, "R7 pending still computed");
        wr(4'd7, 32'h0000_0003);
        chk_irq(1'b1, "R4 irq once both control bits set");
        wait_cyc(2);
        rd(4'd0, 32'h0001_0002, "R8 level captured after capture enabled");
        rd(4'd6, 32'd1, "R3 vector lowest of two");
        wr(4'd7, 32'h0000_0002);
        chk_irq(1'b0, "R4 irq low with output bit clear");

        // R13: unmapped window
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd10, 32'h0000_0000);
        wr(4'd15, 32'hFFFF_FFFF);
        rd(4'd9, 32'h0, "R13 unmapped read zero");
        rd(4'd15, 32'h0, "R13 unmapped read zero top");
        rd(4'd2, 32'h0001_0002, "R13 enable untouched by unmapped write");
        rd(4'd7, 32'h0000_0002, "R13 control untouched by unmapped write");
        rd(4'd0, 32'h0001_0002, "R13 status untouched by unmapped write");

        src = '0;
        wait_cyc(3);
        if (sb_q.size() != 0) begin
            checks++;
            bad++;
            $display("FAIL R10 reads left unanswered: actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule